// File: doc/BRIEF.md
# Parallel Port Operating-Mode Register

This block keeps the three-bit operating-mode field of a parallel port controller's extended control register and decides which mode changes a host write may make. The host writes a whole byte. The mode sits in the top three bits and the lower bits are general register contents. While the port is in the standard or bidirectional mode, a write may select any mode. From every other mode, a write can only return the port to standard or bidirectional. A write that asks for any other mode leaves the mode as it was, but the lower bits are still written.

The block also keeps the direction bit that the host writes through the device control register. It accepts a new direction only while the port is in bidirectional mode. From the mode and that stored direction it derives, with no clock delay, the control outputs that the rest of the port needs:
- the direction the host sees,
- the level of the port direction pin,
- the FIFO enable,
- whether the four control lines drive open-drain or totem-pole.

Reset is asynchronous. The outputs show standard-mode values as soon as reset is applied.

Top module: `ppm_mode_reg`

## Requirements
- R1: While rst_n is low, modeOut is 000, rdData is 0, dirEff, pdirOut and fifoEn are 0 and ctrlOpenDrain is 1. This holds in the same cycle reset is applied, before any clock edge.
- R2: When modeOut is 000 or 001, a host write (wrEn high at a rising clock edge) loads wrData[7:5] into the mode field, whatever its value.
- R3: When modeOut is 010 through 111, a host write loads the mode field only if wrData[7:5] is 000 or 001. Otherwise the mode is unchanged.
- R4: Every host write loads wrData[4:0] into the low register bits, including a write whose mode change is refused.
- R5: A direction write (dcrWrEn high at a rising edge) stores dcrDir only when modeOut is 001 at that edge. In all other modes the stored direction keeps its value, including in mode 011.
- R6: dirEff is 0 in modes 000 and 010. In every other mode it equals the stored direction.
- R7: pdirOut equals the stored direction in modes 001 and 011, and is 0 in all other modes.
- R8: fifoEn is 1 exactly in modes 010, 011 and 110.
- R9: ctrlOpenDrain is 1 exactly in mode 000. In every other mode the control lines are totem-pole (0).
- R10: rdData presents the mode field in bits [7:5] and the low register bits in [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Host write strobe for the mode register |
| wrData | input | 8 | Host write data; mode in [7:5] |
| dcrWrEn | input | 1 | Host write strobe for the direction bit |
| dcrDir | input | 1 | Direction value written with dcrWrEn (1 = input) |
| rdData | output | 8 | Register read-back value |
| modeOut | output | 3 | Current operating mode |
| dirEff | output | 1 | Direction bit as the host sees it |
| pdirOut | output | 1 | Port direction pin level |
| fifoEn | output | 1 | FIFO enable for the current mode |
| ctrlOpenDrain | output | 1 | 1 = control lines open-drain, 0 = totem-pole |

## Verification
The assertions check on every cycle:
- the mode-to-output decode (direction forcing, direction pin gating, FIFO enable, open-drain select);
- that a refused mode write leaves the mode unchanged;
- that the low bits always load;
- that the direction pin stays fixed while the port remains in mode 011.

Some behaviours only the bench's scenarios can show. One is that a direction written in bidirectional mode reappears, unchanged, after a trip through modes that force the direction to zero. Another is that reset takes hold in the middle of a clock cycle. A third is the ordering when a mode write and a direction write fall on the same edge.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  localparam int MODE_W    = 3;
  localparam int NUM_MODES = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MD_STD       = 3'b000,
    MD_BIDIR     = 3'b001,
    MD_FIFO_OUT  = 3'b010,
    MD_ECP       = 3'b011,
    MD_EPP       = 3'b100,
    MD_RSVD      = 3'b101,
    MD_FIFO_TEST = 3'b110,
    MD_CFG       = 3'b111
  } ppMode_e;

  typedef struct packed {
    logic loadLow;
    logic loadMode;
    logic loadDir;
  } ppStrobe_t;

  // A mode from which any other mode may be selected
  function automatic logic isOpenMode(input ppMode_e m);
    return (m == MD_STD) || (m == MD_BIDIR);
  endfunction

  // Per-mode feature lookups, indexed by mode code
  function automatic logic modeHasFifo(input int m);
    return (m == int'(MD_FIFO_OUT)) || (m == int'(MD_ECP)) || (m == int'(MD_FIFO_TEST));
  endfunction

  function automatic logic modeDrivesPdir(input int m);
    return (m == int'(MD_BIDIR)) || (m == int'(MD_ECP));
  endfunction

  function automatic logic modeForcesDirLow(input int m);
    return (m == int'(MD_STD)) || (m == int'(MD_FIFO_OUT));
  endfunction

endpackage

// File: rtl/ppm_ctrl.sv
module ppm_ctrl
  import ppm_pkg::*;
(
  input  logic    wrEn,
  input  ppMode_e reqMode,
  input  ppMode_e curMode,
  input  logic    dcrWrEn,
  output ppStrobe_t strobes
);

  logic modeChangeOk;

  always_comb begin
    // Leaving standard/bidirectional is free; elsewhere only a return is honoured
    modeChangeOk     = isOpenMode(curMode) || isOpenMode(reqMode);
    strobes.loadLow  = wrEn;
    strobes.loadMode = wrEn && modeChangeOk;
    // Direction is writable only while the port is bidirectional
    strobes.loadDir  = dcrWrEn && (curMode == MD_BIDIR);
  end

endmodule

// File: rtl/ppm_decode.sv
module ppm_decode
  import ppm_pkg::*;
(
  input  ppMode_e mode,
  input  logic    dirStored,
  output logic    dirEff,
  output logic    pdirOut,
  output logic    fifoEn,
  output logic    ctrlOpenDrain
);

  logic [NUM_MODES-1:0] fifoTbl;
  logic [NUM_MODES-1:0] pdirTbl;
  logic [NUM_MODES-1:0] dirPassTbl;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_modeTbl
    assign fifoTbl[m]    = modeHasFifo(m);
    assign pdirTbl[m]    = modeDrivesPdir(m);
    assign dirPassTbl[m] = !modeForcesDirLow(m);
  end

  always_comb begin
    fifoEn        = fifoTbl[mode];
    pdirOut       = pdirTbl[mode] & dirStored;
    dirEff        = dirPassTbl[mode] & dirStored;
    ctrlOpenDrain = (mode == MD_STD);
  end

endmodule

// File: rtl/ppm_datapath.sv
module ppm_datapath
  import ppm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ppStrobe_t         strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dcrDir,
  output ppMode_e           modeQ,
  output logic              dirQ,
  output logic [DATA_W-1:0] rdData
);

  localparam int LOW_W = DATA_W - MODE_W;

  logic [LOW_W-1:0] lowQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ <= MD_STD;
      lowQ  <= '0;
      dirQ  <= 1'b0;
    end else begin
      if (strobes.loadMode) modeQ <= ppMode_e'(wrData[DATA_W-1 -: MODE_W]);
      if (strobes.loadLow)  lowQ  <= wrData[LOW_W-1:0];
      if (strobes.loadDir)  dirQ  <= dcrDir;
    end
  end

  assign rdData = {modeQ, lowQ};

endmodule

// File: rtl/ppm_mode_reg.sv
module ppm_mode_reg
  import ppm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dcrWrEn,
  input  logic              dcrDir,
  output logic [DATA_W-1:0] rdData,
  output logic [MODE_W-1:0] modeOut,
  output logic              dirEff,
  output logic              pdirOut,
  output logic              fifoEn,
  output logic              ctrlOpenDrain
);

  ppStrobe_t strobes;
  ppMode_e   modeQ;
  logic      dirQ;

  ppm_ctrl u_ctrl (
    .wrEn    (wrEn),
    .reqMode (ppMode_e'(wrData[DATA_W-1 -: MODE_W])),
    .curMode (modeQ),
    .dcrWrEn (dcrWrEn),
    .strobes (strobes)
  );

  ppm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .wrData  (wrData),
    .dcrDir  (dcrDir),
    .modeQ   (modeQ),
    .dirQ    (dirQ),
    .rdData  (rdData)
  );

  ppm_decode u_dec (
    .mode          (modeQ),
    .dirStored     (dirQ),
    .dirEff        (dirEff),
    .pdirOut       (pdirOut),
    .fifoEn        (fifoEn),
    .ctrlOpenDrain (ctrlOpenDrain)
  );

  assign modeOut = modeQ;

endmodule

// File: rtl/ppm_mode_reg_chk.sv
module ppm_mode_reg_chk
  import ppm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              dcrWrEn,
  input logic              dcrDir,
  input logic [DATA_W-1:0] rdData,
  input logic [MODE_W-1:0] modeOut,
  input logic              dirEff,
  input logic              pdirOut,
  input logic              fifoEn,
  input logic              ctrlOpenDrain
);

  localparam int LOW_W = DATA_W - MODE_W;

  logic [MODE_W-1:0] reqMode;
  assign reqMode = wrData[DATA_W-1 -: MODE_W];

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_defaults_chk: assert (modeOut == '0 && rdData == '0 && !dirEff && !pdirOut
                                  && !fifoEn && ctrlOpenDrain);
    end
  end

  // R2
  open_mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && modeOut <= 3'd1) |=> (modeOut == $past(reqMode)));

  // R3
  locked_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && modeOut > 3'd1 && reqMode > 3'd1) |=> $stable(modeOut));

  // R4
  low_bits_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> (rdData[LOW_W-1:0] == $past(wrData[LOW_W-1:0])));

  // R5
  dir_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dcrWrEn && modeOut == 3'd1 && !wrEn) |=> (pdirOut == $past(dcrDir)));

  // R5
  ecp_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 3'd3 && $past(modeOut) == 3'd3) |-> $stable(pdirOut));

  // R6
  forced_dir_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 3'd0 || modeOut == 3'd2) |-> (!dirEff && !pdirOut));

  // R7
  pdir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdirOut |-> (modeOut == 3'd1 || modeOut == 3'd3) && dirEff);

  // R8
  fifo_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoEn |-> (modeOut == 3'd2 || modeOut == 3'd3 || modeOut == 3'd6));

  // R8
  fifo_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 3'd2 || modeOut == 3'd3 || modeOut == 3'd6) |-> fifoEn);

  // R9
  open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlOpenDrain == (modeOut == 3'd0));

  // R10
  readback_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdData[DATA_W-1 -: MODE_W] == modeOut);

  logic unusedOk;
  assign unusedOk = dcrWrEn;

endmodule

bind ppm_mode_reg ppm_mode_reg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ppm_mode_reg_bench.sv
`timescale 1ns/1ps
module ppm_mode_reg_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       dcrWrEn = 1'b0;
  logic       dcrDir = 1'b0;
  logic [7:0] rdData;
  logic [2:0] modeOut;
  logic       dirEff, pdirOut, fifoEn, ctrlOpenDrain;

  int total = 0;
  int failed = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  int refMode = 0;
  int refLow  = 0;
  int refDir  = 0;

  always #2.5 clk = ~clk;

  ppm_mode_reg u_ppm_mode_reg (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expDirEff(int m, int d);
    if (m == 0 || m == 2) return 0;
    return d;
  endfunction
  function automatic int expPdir(int m, int d);
    if (m == 1 || m == 3) return d;
    return 0;
  endfunction
  function automatic int expFifo(int m);
    return (m == 2 || m == 3 || m == 6) ? 1 : 0;
  endfunction

  // reference model: one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refMode = 0; refLow = 0; refDir = 0;
    end else begin
      int nm;
      if (dcrWrEn && refMode == 1) refDir = dcrDir;
      if (wrEn) begin
        refLow = wrData[4:0];
        nm = wrData[7:5];
        if (refMode <= 1 || nm <= 1) refMode = nm;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(modeOut == refMode[2:0], "R2 R3 mode", modeOut, refMode);
      chk(rdData == {refMode[2:0], refLow[4:0]}, "R4 R10 rdData", rdData, {refMode[2:0], refLow[4:0]});
      chk(dirEff == expDirEff(refMode, refDir), "R5 R6 dirEff", dirEff, expDirEff(refMode, refDir));
      chk(pdirOut == expPdir(refMode, refDir), "R5 R7 pdirOut", pdirOut, expPdir(refMode, refDir));
      chk(fifoEn == expFifo(refMode), "R8 fifoEn", fifoEn, expFifo(refMode));
      chk(ctrlOpenDrain == (refMode == 0), "R9 ctrlOpenDrain", ctrlOpenDrain, refMode == 0);
    end
  end

  task automatic checkResetState();
    chk(modeOut == 0, "R1 mode", modeOut, 0);
    chk(rdData == 0, "R1 rdData", rdData, 0);
    chk(!dirEff && !pdirOut, "R1 dir", {dirEff, pdirOut}, 0);
    chk(!fifoEn, "R1 fifoEn", fifoEn, 0);
    chk(ctrlOpenDrain, "R1 openDrain", ctrlOpenDrain, 1);
  endtask

  task automatic hostWr(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic dirWr(input logic d);
    @(negedge clk);
    dcrWrEn = 1'b1; dcrDir = d;
    @(negedge clk);
    dcrWrEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++; failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    #1;
    checkResetState();                    // R1 at time zero
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    hostWr({3'b001, 5'h15});              // R2 standard -> bidirectional
    dirWr(1'b1);                          // R5 direction taken in mode 001
    hostWr({3'b011, 5'h0A});              // R2 bidirectional -> ECP, R7 pdir follows
    dirWr(1'b0);                          // R5 ignored in mode 011
    chk(pdirOut == 1'b1, "R5 ecp hold", pdirOut, 1);
    hostWr({3'b100, 5'h1F});              // R3 refused, R4 low bits still written
    chk(modeOut == 3'b011 && rdData[4:0] == 5'h1F, "R3 R4 refused write", rdData, {3'b011, 5'h1F});
    hostWr({3'b000, 5'h01});              // R3 return allowed
    hostWr({3'b010, 5'h02});              // R6 direction forced low
    chk(dirEff == 1'b0, "R6 forced", dirEff, 0);
    hostWr({3'b110, 5'h03});              // R3 refused from 010
    hostWr({3'b001, 5'h04});              // stored direction visible again
    chk(dirEff == 1'b1, "R6 restored", dirEff, 1);
    hostWr({3'b110, 5'h05});              // R8 FIFO test mode
    hostWr({3'b111, 5'h06});              // R3 refused
    hostWr({3'b000, 5'h07});
    hostWr({3'b101, 5'h08});              // R2 reserved reachable from 000
    hostWr({3'b001, 5'h09});
    // same-edge mode write and direction write: direction uses the old mode
    @(negedge clk);
    wrEn = 1'b1; wrData = {3'b011, 5'h10}; dcrWrEn = 1'b1; dcrDir = 1'b0;
    @(negedge clk);
    wrEn = 1'b0; dcrWrEn = 1'b0;
    chk(pdirOut == 1'b0, "R5 same edge", pdirOut, 0);

    // R1 reset applied mid-cycle
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5 checkResetState();
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      wrEn    = ($urandom_range(0, 2) == 0);
      wrData  = 8'($urandom);
      dcrWrEn = ($urandom_range(0, 2) == 0);
      dcrDir  = 1'($urandom);
      if ($urandom_range(0, 3) == 0) wrData[7:6] = 2'b00;
    end
    @(negedge clk);
    wrEn = 1'b0; dcrWrEn = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule